// File: doc/BRIEF.md
# Multiprocessor Serial Receiver with Ninth-Bit Parity

This block turns an asynchronous serial line into bytes. Each frame carries a low start bit, eight data bits sent least significant bit first, and an optional ninth bit, and it closes with one stop bit. The ninth bit serves one of two purposes. With the extra-bit function on, it is a plain flag that marks an address byte (1) or a data byte (0). With parity on, it is a parity bit that is checked against one of four selectable rules. Parity takes precedence, so the two functions never apply together.

Received bytes go into a small queue. The read side always shows the oldest byte, together with its ninth-bit value. When the extra-bit function is inactive, that ninth-bit value is the frame's stop bit. A one-cycle interrupt pulse marks every byte that enters the queue. In multiprocessor mode, a byte whose ninth-bit value is 0 is discarded and raises no interrupt. A listener therefore wakes up only for address bytes until software turns the mode off. Sticky flags record parity mismatches, stop-bit errors and queue overruns, and a single clear input resets all three.

Top module: `mp_uart_rx`

## Requirements
- R1: After reset, rd_valid, rx_irq, par_err, frm_err and ovr_err are all 0.
- R2: A frame is one low start bit, 8 data bits least significant bit first, the ninth bit when cfg_xbit_en or cfg_par_en is 1, and one stop bit. Each bit lasts 16 × BAUD_DIV clocks. The data bits appear unchanged on rd_data.
- R3: If the line is no longer low at the middle of a start bit, the low pulse is ignored. No byte is queued and no interrupt is raised.
- R4: With cfg_xbit_en=1 and cfg_par_en=0, rd_ninth shows the received ninth bit (1 = address byte, 0 = data byte).
- R5: With the extra-bit function inactive (cfg_xbit_en=0 or cfg_par_en=1), rd_ninth shows the stop-bit value received with that byte.
- R6: With cfg_par_en=1, the ninth bit is compared with the expected parity for cfg_par_sel: 00 odd (data plus parity has an odd count of ones), 01 even, 10 always 1, 11 always 0. A mismatch sets par_err. The byte is still queued.
- R7: par_err stays set through later frames, including frames with correct parity, until err_clr is asserted.
- R8: With cfg_mp_en=1, a byte whose ninth-bit value (as defined in R4 and R5) is 0 is neither queued nor signalled. A byte whose ninth-bit value is 1 is queued and raises rx_irq.
- R9: With cfg_mp_en=0, every byte that is queued produces exactly one single-cycle rx_irq pulse.
- R10: The queue holds 4 bytes and presents them oldest first. A pulse on rd_en removes the head. A byte that arrives while the queue is full is dropped, gives no interrupt, and sets ovr_err.
- R11: A stop bit sampled low sets frm_err.
- R12: err_clr clears par_err, frm_err and ovr_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Serial receive line, idle high |
| cfg_mp_en | input | 1 | Multiprocessor mode: keep only bytes whose ninth-bit value is 1 |
| cfg_par_en | input | 1 | Treat the ninth bit as parity |
| cfg_par_sel | input | 2 | Parity rule: 00 odd, 01 even, 10 one, 11 zero |
| cfg_xbit_en | input | 1 | Receive the ninth bit as an address/data flag |
| rd_en | input | 1 | Remove the queue head |
| err_clr | input | 1 | Clear all sticky error flags |
| rd_data | output | 8 | Oldest queued byte |
| rd_ninth | output | 1 | Ninth-bit value of the oldest queued byte |
| rd_valid | output | 1 | Queue not empty |
| rx_irq | output | 1 | One-cycle pulse per queued byte |
| par_err | output | 1 | Sticky parity mismatch flag |
| frm_err | output | 1 | Sticky stop-bit error flag |
| ovr_err | output | 1 | Sticky overrun flag |

## Verification
The assertions assume that the configuration inputs do not change while a frame is in flight. They also assume that rd_en is pulsed only between frames, never in the cycle a byte is pushed, and that err_clr never lands in the same cycle as a flag being set. The bench changes configuration, pops bytes and clears flags only after a frame's stop bit has finished and the line has been idle for a few clocks. It drives each bit for exactly one full bit period, so every mid-bit sample reads a settled level.

// File: rtl/mpu_pkg.sv
package mpu_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_BITS,
    ST_STOP
  } rx_state_e;

  // Expected value of the ninth bit under the selected parity rule.
  function automatic logic exp_parity(input logic [1:0] sel, input logic [7:0] data);
    logic ones_odd;
    ones_odd = ^data;
    case (sel)
      2'b00:   exp_parity = ~ones_odd;  // odd total
      2'b01:   exp_parity = ones_odd;   // even total
      2'b10:   exp_parity = 1'b1;
      default: exp_parity = 1'b0;
    endcase
  endfunction

  // Number of bits between start and stop.
  function automatic logic [3:0] payload_bits(input logic ninth_on);
    payload_bits = ninth_on ? 4'd9 : 4'd8;
  endfunction

endpackage

// File: rtl/mpu_rx_bitengine.sv
module mpu_rx_bitengine #(
  parameter int OSR      = 16,
  parameter int BAUD_DIV = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_i,
  input  logic       ninth_on,
  output logic       frame_done,
  output logic [7:0] frame_data,
  output logic       frame_ninth,
  output logic       frame_stop
);
  import mpu_pkg::*;

  localparam int OS_W = $clog2(OSR);
  localparam int HALF = OSR / 2;

  logic tick;

  generate
    if (BAUD_DIV == 1) begin : g_tick_full
      assign tick = 1'b1;
    end else begin : g_tick_div
      localparam int DIV_W = $clog2(BAUD_DIV);
      logic [DIV_W-1:0] div_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else if (div_q == DIV_W'(BAUD_DIV - 1)) div_q <= '0;
        else div_q <= div_q + 1'b1;
      end
      assign tick = (div_q == DIV_W'(BAUD_DIV - 1));
    end
  endgenerate

  logic            rx_s1, rx_s2;
  rx_state_e       state_q;
  logic [OS_W-1:0] os_q;
  logic [3:0]      idx_q;
  logic [3:0]      nbits_q;
  logic [8:0]      shift_q;
  logic            done_q, stop_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_s1 <= 1'b1;
      rx_s2 <= 1'b1;
    end else begin
      rx_s1 <= rx_i;
      rx_s2 <= rx_s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      os_q    <= '0;
      idx_q   <= '0;
      nbits_q <= 4'd8;
      shift_q <= '0;
      done_q  <= 1'b0;
      stop_q  <= 1'b1;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          os_q <= '0;
          if (!rx_s2) begin
            state_q <= ST_START;
            nbits_q <= payload_bits(ninth_on);
            shift_q <= '0;
          end
        end
        ST_START: if (tick) begin
          if (os_q == OS_W'(HALF - 1)) begin
            os_q    <= '0;
            idx_q   <= '0;
            state_q <= rx_s2 ? ST_IDLE : ST_BITS;
          end else begin
            os_q <= os_q + 1'b1;
          end
        end
        ST_BITS: if (tick) begin
          if (os_q == OS_W'(OSR - 1)) begin
            os_q           <= '0;
            shift_q[idx_q] <= rx_s2;
            if (idx_q == nbits_q - 4'd1) state_q <= ST_STOP;
            else idx_q <= idx_q + 4'd1;
          end else begin
            os_q <= os_q + 1'b1;
          end
        end
        default: if (tick) begin
          if (os_q == OS_W'(OSR - 1)) begin
            os_q    <= '0;
            done_q  <= 1'b1;
            stop_q  <= rx_s2;
            state_q <= ST_IDLE;
          end else begin
            os_q <= os_q + 1'b1;
          end
        end
      endcase
    end
  end

  assign frame_done  = done_q;
  assign frame_data  = shift_q[7:0];
  assign frame_ninth = shift_q[8];
  assign frame_stop  = stop_q;
endmodule

// File: rtl/mpu_rx_fifo.sv
module mpu_rx_fifo #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [WIDTH-1:0]             wdata,
  input  logic                         pop,
  output logic [WIDTH-1:0]             rdata,
  output logic                         empty,
  output logic                         full,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wp_q, rp_q;
  logic [CNT_W-1:0] cnt_q;
  logic do_push, do_pop;

  assign do_push = push && (cnt_q != CNT_W'(DEPTH));
  assign do_pop  = pop && (cnt_q != '0);

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    bump = (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= bump(wp_q);
      if (do_pop)  rp_q <= bump(rp_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wp_q] <= wdata;
  end

  assign rdata = mem_q[rp_q];
  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CNT_W'(DEPTH));
  assign count = cnt_q;
endmodule

// File: rtl/mp_uart_rx.sv
module mp_uart_rx #(
  parameter int OSR        = 16,
  parameter int BAUD_DIV   = 1,
  parameter int FIFO_DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_i,
  input  logic       cfg_mp_en,
  input  logic       cfg_par_en,
  input  logic [1:0] cfg_par_sel,
  input  logic       cfg_xbit_en,
  input  logic       rd_en,
  input  logic       err_clr,
  output logic [7:0] rd_data,
  output logic       rd_ninth,
  output logic       rd_valid,
  output logic       rx_irq,
  output logic       par_err,
  output logic       frm_err,
  output logic       ovr_err
);
  import mpu_pkg::*;

  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

  logic       frame_done, frame_ninth, frame_stop;
  logic [7:0] frame_data;
  logic       ninth_on, xbit_active, kept_ninth;
  logic       par_bad, frame_keep, push, fifo_full, fifo_empty;
  logic [8:0] head;
  logic [CNT_W-1:0] fifo_count;
  logic       irq_q, perr_q, ferr_q, oerr_q;

  assign ninth_on    = cfg_xbit_en | cfg_par_en;
  assign xbit_active = cfg_xbit_en & ~cfg_par_en;

  mpu_rx_bitengine #(.OSR(OSR), .BAUD_DIV(BAUD_DIV)) u_bits (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_i       (rx_i),
    .ninth_on   (ninth_on),
    .frame_done (frame_done),
    .frame_data (frame_data),
    .frame_ninth(frame_ninth),
    .frame_stop (frame_stop)
  );

  assign kept_ninth = xbit_active ? frame_ninth : frame_stop;
  assign par_bad    = cfg_par_en && (frame_ninth != exp_parity(cfg_par_sel, frame_data));
  assign frame_keep = frame_done && (!cfg_mp_en || kept_ninth);
  assign push       = frame_keep && !fifo_full;

  mpu_rx_fifo #(.WIDTH(9), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk  (clk),
    .rst_n(rst_n),
    .push (push),
    .wdata({kept_ninth, frame_data}),
    .pop  (rd_en),
    .rdata(head),
    .empty(fifo_empty),
    .full (fifo_full),
    .count(fifo_count)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q  <= 1'b0;
      perr_q <= 1'b0;
      ferr_q <= 1'b0;
      oerr_q <= 1'b0;
    end else begin
      irq_q <= push;
      if (frame_done && par_bad)       perr_q <= 1'b1;
      else if (err_clr)                perr_q <= 1'b0;
      if (frame_done && !frame_stop)   ferr_q <= 1'b1;
      else if (err_clr)                ferr_q <= 1'b0;
      if (frame_keep && fifo_full)     oerr_q <= 1'b1;
      else if (err_clr)                oerr_q <= 1'b0;
    end
  end

  assign rd_data  = head[7:0];
  assign rd_ninth = head[8];
  assign rd_valid = !fifo_empty;
  assign rx_irq   = irq_q;
  assign par_err  = perr_q;
  assign frm_err  = ferr_q;
  assign ovr_err  = oerr_q;
endmodule

// File: rtl/mpu_rx_checker.sv
module mpu_rx_checker #(
  parameter int DEPTH = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       cfg_mp_en,
  input logic                       frame_done,
  input logic                       kept_ninth,
  input logic                       fifo_full,
  input logic [$clog2(DEPTH+1)-1:0] fifo_count,
  input logic                       rd_en,
  input logic                       rd_valid,
  input logic                       rx_irq,
  input logic                       err_clr,
  input logic                       par_err,
  input logic                       ovr_err
);
  AST_MP_FILTER: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && cfg_mp_en && !kept_ninth |=> !rx_irq); // R8

  AST_IRQ_FROM_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> $past(frame_done)); // R9

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |=> !rx_irq); // R9

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= ($clog2(DEPTH+1))'(DEPTH)); // R10

  AST_OVR_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && (!cfg_mp_en || kept_ninth) && fifo_full && !rd_en |=> ovr_err && !rx_irq); // R10

  AST_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !rd_valid && !frame_done |=> $stable(fifo_count)); // R10

  AST_PERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    par_err && !err_clr |=> par_err); // R7

  AST_CLR_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr && !frame_done |=> !par_err && !ovr_err); // R12
endmodule

bind mp_uart_rx mpu_rx_checker #(.DEPTH(FIFO_DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_mp_en (cfg_mp_en),
  .frame_done(frame_done),
  .kept_ninth(kept_ninth),
  .fifo_full (fifo_full),
  .fifo_count(fifo_count),
  .rd_en     (rd_en),
  .rd_valid  (rd_valid),
  .rx_irq    (rx_irq),
  .err_clr   (err_clr),
  .par_err   (par_err),
  .ovr_err   (ovr_err)
);

// File: tb/mp_uart_rx_bench.sv
`timescale 1ns/1ps
module mp_uart_rx_bench;
  localparam int BIT_CLKS = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_i = 1'b1;
  logic cfg_mp_en = 1'b0, cfg_par_en = 1'b0, cfg_xbit_en = 1'b0;
  logic [1:0] cfg_par_sel = 2'b00;
  logic rd_en = 1'b0, err_clr = 1'b0;
  logic [7:0] rd_data;
  logic rd_ninth, rd_valid, rx_irq, par_err, frm_err, ovr_err;

  int checks = 0;
  int errors = 0;
  int irq_cnt = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  mp_uart_rx u_mp_uart_rx (
    .clk(clk), .rst_n(rst_n), .rx_i(rx_i),
    .cfg_mp_en(cfg_mp_en), .cfg_par_en(cfg_par_en), .cfg_par_sel(cfg_par_sel),
    .cfg_xbit_en(cfg_xbit_en), .rd_en(rd_en), .err_clr(err_clr),
    .rd_data(rd_data), .rd_ninth(rd_ninth), .rd_valid(rd_valid),
    .rx_irq(rx_irq), .par_err(par_err), .frm_err(frm_err), .ovr_err(ovr_err)
  );

  always @(posedge clk) if (rst_n && rx_irq) irq_cnt <= irq_cnt + 1;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic line_bit(input logic v);
    rx_i = v;
    idle(BIT_CLKS);
  endtask

  task automatic send(input logic [7:0] d, input bit has9, input logic b9, input logic stop);
    line_bit(1'b0);
    for (int i = 0; i < 8; i++) line_bit(d[i]);
    if (has9) line_bit(b9);
    line_bit(stop);
    rx_i = 1'b1;
    idle(6);
  endtask

  task automatic pop();
    rd_en = 1'b1;
    idle(1);
    rd_en = 1'b0;
    idle(1);
  endtask

  task automatic clear();
    err_clr = 1'b1;
    idle(1);
    err_clr = 1'b0;
    idle(1);
  endtask

  function automatic logic bench_par(input logic [1:0] sel, input logic [7:0] d);
    int ones = 0;
    for (int i = 0; i < 8; i++) ones += int'(d[i]);
    case (sel)
      2'b00: return (ones % 2 == 0) ? 1'b1 : 1'b0;
      2'b01: return (ones % 2 == 1) ? 1'b1 : 1'b0;
      2'b10: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int base;
    logic [7:0] d;
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    chk("R1 rd_valid", rd_valid, 0);
    chk("R1 rx_irq", rx_irq, 0);
    chk("R1 flags", {par_err, frm_err, ovr_err}, 0);

    // R2 R5 R9: plain 8-bit frames, data sweep
    for (int k = 0; k < 12; k++) begin
      d = 8'((k * 37) ^ 8'hA5);
      if (k == 0) d = 8'h00;
      if (k == 1) d = 8'hFF;
      base = irq_cnt;
      send(d, 0, 1'b0, 1'b1);
      chk("R2 valid", rd_valid, 1);
      chk("R2 data", rd_data, d);
      chk("R5 ninth=stop", rd_ninth, 1);
      chk("R9 irq count", irq_cnt - base, 1);
      pop();
      chk("R10 empty after pop", rd_valid, 0);
    end

    // R11 framing error, R5 ninth shows low stop, R12 clear
    send(8'h3C, 0, 1'b0, 1'b0);
    idle(40);
    chk("R11 frm_err", frm_err, 1);
    chk("R5 ninth low stop", rd_ninth, 0);
    chk("R11 data", rd_data, 8'h3C);
    pop();
    chk("R3 no false start after bad stop", rd_valid, 0);
    clear();
    chk("R12 frm cleared", frm_err, 0);

    // R3 glitch rejection
    base = irq_cnt;
    rx_i = 1'b0;
    idle(4);
    rx_i = 1'b1;
    idle(60);
    chk("R3 no byte", rd_valid, 0);
    chk("R3 no irq", irq_cnt - base, 0);

    // R4 extra bit
    cfg_xbit_en = 1'b1;
    for (int b = 0; b < 2; b++) begin
      send(8'h5A + 8'(b), 1, 1'(b), 1'b1);
      chk("R4 data", rd_data, 8'h5A + b);
      chk("R4 ninth", rd_ninth, b);
      pop();
    end

    // R6 parity sweep: all rules, several bytes, both ninth values
    cfg_par_en = 1'b1;
    for (int s = 0; s < 4; s++) begin
      cfg_par_sel = 2'(s);
      for (int k = 0; k < 6; k++) begin
        for (int b = 0; b < 2; b++) begin
          d = 8'((k * 53 + s * 11) ^ 8'h6E);
          send(d, 1, 1'(b), 1'b1);
          chk("R6 par_err", par_err, (1'(b) != bench_par(2'(s), d)) ? 1 : 0);
          chk("R6 data", rd_data, d);
          chk("R5 ninth=stop under parity", rd_ninth, 1);
          pop();
          clear();
        end
      end
    end

    // R7 sticky parity error
    cfg_par_sel = 2'b01;
    send(8'h07, 1, ~bench_par(2'b01, 8'h07), 1'b1);
    chk("R7 set", par_err, 1);
    pop();
    send(8'h07, 1, bench_par(2'b01, 8'h07), 1'b1);
    chk("R7 held through good frame", par_err, 1);
    pop();
    clear();
    chk("R12 par cleared", par_err, 0);
    cfg_par_en = 1'b0;

    // R8 multiprocessor filter
    cfg_mp_en = 1'b1;
    base = irq_cnt;
    send(8'h11, 1, 1'b0, 1'b1);
    chk("R8 data byte not queued", rd_valid, 0);
    chk("R8 data byte no irq", irq_cnt - base, 0);
    send(8'h22, 1, 1'b1, 1'b1);
    chk("R8 address queued", rd_valid, 1);
    chk("R8 address data", rd_data, 8'h22);
    chk("R8 address ninth", rd_ninth, 1);
    chk("R8 address irq", irq_cnt - base, 1);
    pop();
    cfg_mp_en = 1'b0;
    base = irq_cnt;
    send(8'h33, 1, 1'b0, 1'b1);
    chk("R9 data byte seen with mp off", rd_data, 8'h33);
    chk("R9 irq mp off", irq_cnt - base, 1);
    pop();
    cfg_xbit_en = 1'b0;

    // R10 depth, order, overrun
    base = irq_cnt;
    for (int k = 0; k < 4; k++) send(8'(8'h80 + k), 0, 1'b0, 1'b1);
    chk("R10 no overrun at 4", ovr_err, 0);
    send(8'hEE, 0, 1'b0, 1'b1);
    chk("R10 overrun", ovr_err, 1);
    chk("R10 irq only for queued", irq_cnt - base, 4);
    for (int k = 0; k < 4; k++) begin
      chk("R10 order", rd_data, 8'h80 + k);
      pop();
    end
    chk("R10 dropped byte absent", rd_valid, 0);
    clear();
    chk("R12 ovr cleared", ovr_err, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule